// File: doc/BRIEF.md
# Line Status Change-of-State Interrupt Controller

This block watches a group of line condition flags (loss of signal, alarm indication, network loopback, pseudo-random pattern lock and two framing monitor flags) and two elastic-buffer event inputs (overflow and underflow). The host interrupt is active low. It asserts when any status flag toggles, in either direction, or when a buffer event pulse arrives. Each source has a sticky pending latch. The interrupt is held for as long as any pending latch is set on a source that is not masked.

Software finds the cause through a status read port. That port returns the sampled line flags together with the two buffer-event pending flags. A single clear/mask write port acknowledges sources. Writing a one to a source's bit clears its latch and masks it. Writing a zero enables it again. The pin is open drain, so the block outputs a pull-low enable, plus the level that the pin shows through its external pull-up.

Generate options cover two choices: an input synchronizer of zero to three stages on the line flags, and an extra output register on the pull-low enable. The timing described below assumes both are off, which is the default.

Top module: `lsi_irq_ctrl`

## Requirements
- R1: A change of any single line flag, or of several at once, in either direction, on an enabled source sets that source's latch on the next rising edge. From that edge on, irq_pull_low is 1.
- R2: A one on evt_in[0] (overflow) or evt_in[1] (underflow) in a cycle, on an enabled source, sets its latch on that edge and asserts irq_pull_low.
- R3: A latch stays set after its cause goes away, for example when a flag returns to its old value. The interrupt stays asserted until the latch is cleared.
- R4: A write with wr_data[i]=1 clears latch i. Bits 0..5 are the line flags, bit 6 is overflow and bit 7 is underflow. irq_pull_low drops on the edge of the write only when no other enabled latch is still set.
- R5: While a source's mask bit is 1, its events are not latched and do not assert the interrupt. A write with wr_data[i]=0 enables source i again. Events that arrived while it was masked are not remembered.
- R6: An event in the same cycle as a write is qualified by the mask in force before that write. A write of one to a source therefore wins over a simultaneous event on that source.
- R7: rd_status[5:0] holds the line flags sampled on the last rising edge. rd_status[6] is the overflow pending latch and rd_status[7] is the underflow pending latch. The port is a pure read and changes no state.
- R8: After reset all masks are 0, all latches are clear and the interrupt is released. The first sample taken after reset is not treated as a change, whatever the flag values are.
- R9: irq_n is 0 exactly when irq_pull_low is 1, and 1 otherwise. This models the external pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_in | input | 6 | Line condition flags |
| evt_in | input | 2 | Elastic-buffer event pulses: [0] overflow, [1] underflow |
| wr_en | input | 1 | Clear/mask register write strobe |
| wr_data | input | 8 | Clear/mask value, one bit per source |
| rd_status | output | 8 | Status register read value |
| irq_pull_low | output | 1 | Open-drain enable: 1 drives the interrupt pin low |
| irq_n | output | 1 | Interrupt pin level with the pull-up applied |

## Verification
The bench toggles every line flag in both directions, and then every one of the 63 non-empty multi-flag patterns. A detector that looks only at rising edges, or a reduction that drops a bit, leaves the interrupt released for some of these patterns. It releases a flag back to its old value, to catch a level-following latch in place of a sticky one. It also clears one of two pending sources, to catch a design that drops the interrupt on any clear. It lines up events with the clear/mask write on the same edge and with the re-enable write on the same edge, which exposes a design that ranks events above clears or qualifies events with the new mask. Reset with non-zero flags exposes a detector that compares against the reset value of its history register.

// File: rtl/lsi_irq_pkg.sv
package lsi_irq_pkg;

   // Bit positions of the elastic-buffer events inside the event vector
   localparam int unsigned EVT_OVF = 0;
   localparam int unsigned EVT_UFL = 1;

   // Next value of one pending latch.
   // A clear has priority, then an event qualified by the old mask.
   function automatic logic pend_next(input logic pend_q,
                                      input logic evt,
                                      input logic mask_q,
                                      input logic clr);
      logic nxt;
      if (clr)
         nxt = 1'b0;
      else if (evt && !mask_q)
         nxt = 1'b1;
      else
         nxt = pend_q;
      return nxt;
   endfunction

endpackage

// File: rtl/lsi_cos_detect.sv
module lsi_cos_detect #(
   parameter int unsigned W           = 6,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_in,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] chg
);

   localparam int unsigned ARM_LAST = SYNC_STAGES + 1;
   localparam int unsigned ARM_W    = $clog2(SYNC_STAGES + 2);

   logic [W-1:0]     stat_s;
   logic [W-1:0]     prev_q;
   logic [ARM_W-1:0] arm_cnt;
   logic             armed;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign stat_s = stat_in;
      end else begin : g_sync
         logic [W-1:0] sync_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
            end else begin
               sync_q[0] <= stat_in;
               for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
            end
         end
         assign stat_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   // History register plus an arming counter, so that the reset
   // value of the history is never compared against live flags.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         arm_cnt <= '0;
      end else begin
         prev_q <= stat_s;
         if (arm_cnt != ARM_W'(ARM_LAST)) arm_cnt <= arm_cnt + 1'b1;
      end
   end

   assign armed  = (arm_cnt == ARM_W'(ARM_LAST));
   assign chg    = armed ? (stat_s ^ prev_q) : '0;
   assign stat_q = prev_q;

endmodule

// File: rtl/lsi_pend_bank.sv
module lsi_pend_bank
   import lsi_irq_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] pend,
   output logic [W-1:0] mask
);

   logic [W-1:0] clr;
   assign clr = wr_en ? wr_data : '0;

   generate
      for (genvar i = 0; i < W; i++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend[i] <= 1'b0;
               mask[i] <= 1'b0;
            end else begin
               pend[i] <= pend_next(pend[i], evt[i], mask[i], clr[i]);
               if (wr_en) mask[i] <= wr_data[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lsi_irq_drive.sv
module lsi_irq_drive #(
   parameter int unsigned W       = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend,
   input  logic [W-1:0] mask,
   output logic         pull_low
);

   logic req;
   assign req = |(pend & ~mask);

   generate
      if (REG_OUT) begin : g_reg
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= req;
         end
         assign pull_low = req_q;
      end else begin : g_comb
         assign pull_low = req;
      end
   endgenerate

endmodule

// File: rtl/lsi_irq_ctrl.sv
module lsi_irq_ctrl
   import lsi_irq_pkg::*;
#(
   parameter int unsigned STAT_W      = 6,
   parameter int unsigned EVT_W       = 2,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          REG_OUT     = 1'b0,
   localparam int unsigned SRC_W      = STAT_W + EVT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_in,
   input  logic [EVT_W-1:0]  evt_in,
   input  logic              wr_en,
   input  logic [SRC_W-1:0]  wr_data,
   output logic [SRC_W-1:0]  rd_status,
   output logic              irq_pull_low,
   output logic              irq_n
);

   generate
      if (STAT_W < 1 || STAT_W > 32) begin : g_bad_stat
         $error("lsi_irq_ctrl: STAT_W out of range");
      end
      if (EVT_W <= EVT_UFL) begin : g_bad_evt
         $error("lsi_irq_ctrl: EVT_W must hold overflow and underflow");
      end
      if (SYNC_STAGES > 3) begin : g_bad_sync
         $error("lsi_irq_ctrl: SYNC_STAGES must be 0..3");
      end
   endgenerate

   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] chg;
   logic [SRC_W-1:0]  pend;
   logic [SRC_W-1:0]  mask;
   logic [SRC_W-1:0]  src_evt;

   lsi_cos_detect #(
      .W           (STAT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cos (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_in (stat_in),
      .stat_q  (stat_q),
      .chg     (chg)
   );

   assign src_evt = {evt_in, chg};

   lsi_pend_bank #(
      .W (SRC_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (src_evt),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .pend    (pend),
      .mask    (mask)
   );

   lsi_irq_drive #(
      .W       (SRC_W),
      .REG_OUT (REG_OUT)
   ) u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (pend),
      .mask     (mask),
      .pull_low (irq_pull_low)
   );

   assign rd_status = {pend[SRC_W-1:STAT_W], stat_q};
   assign irq_n     = ~irq_pull_low;

endmodule

// File: rtl/lsi_irq_ctrl_chk.sv
module lsi_irq_ctrl_chk #(
   parameter int unsigned STAT_W      = 6,
   parameter int unsigned EVT_W       = 2,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          REG_OUT     = 1'b0,
   localparam int unsigned SRC_W      = STAT_W + EVT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STAT_W-1:0] stat_in,
   input logic [EVT_W-1:0]  evt_in,
   input logic              wr_en,
   input logic [SRC_W-1:0]  wr_data,
   input logic [SRC_W-1:0]  rd_status,
   input logic              irq_pull_low
);

   logic [SRC_W-1:0]  msk_sh;
   logic              armed_sh;
   logic [STAT_W-1:0] stat_prev;
   logic [SRC_W-1:0]  raw_evt;
   logic [SRC_W-1:0]  clr;
   logic [SRC_W-1:0]  live_v;
   logic [EVT_W-1:0]  evt_live;
   logic              live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msk_sh    <= '0;
         armed_sh  <= 1'b0;
         stat_prev <= '0;
      end else begin
         if (wr_en) msk_sh <= wr_data;
         armed_sh  <= 1'b1;
         stat_prev <= stat_in;
      end
   end

   assign raw_evt  = {evt_in, (armed_sh ? (stat_in ^ stat_prev) : {STAT_W{1'b0}})};
   assign clr      = wr_en ? wr_data : '0;
   assign live_v   = raw_evt & ~msk_sh & ~clr;
   assign live     = |live_v;
   assign evt_live = live_v[SRC_W-1:STAT_W];

   generate
      if (SYNC_STAGES == 0 && REG_OUT == 1'b0) begin : g_timing
         AST_EVENT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            live |=> irq_pull_low); // R1
         AST_BUF_EVT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_live != '0) |=> ((rd_status[SRC_W-1:STAT_W] & $past(evt_live)) == $past(evt_live))); // R2
         AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pull_low && !wr_en) |=> irq_pull_low); // R3
         AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (&wr_data)) |=> !irq_pull_low); // R4
         AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_pull_low && !live) |=> !irq_pull_low); // R5
         AST_RD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            armed_sh |-> (rd_status[STAT_W-1:0] == stat_prev)); // R7
      end
   endgenerate

endmodule

bind lsi_irq_ctrl lsi_irq_ctrl_chk #(
   .STAT_W      (STAT_W),
   .EVT_W       (EVT_W),
   .SYNC_STAGES (SYNC_STAGES),
   .REG_OUT     (REG_OUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stat_in      (stat_in),
   .evt_in       (evt_in),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .rd_status    (rd_status),
   .irq_pull_low (irq_pull_low)
);

// File: tb/lsi_irq_ctrl_tb.sv
module lsi_irq_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] stat_in = '0;
   logic [1:0] evt_in = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_status;
   logic       irq_pull_low;
   logic       irq_n;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   lsi_irq_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .stat_in      (stat_in),
      .evt_in       (evt_in),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_status    (rd_status),
      .irq_pull_low (irq_pull_low),
      .irq_n        (irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // The irq level and its pin view are checked together
   task automatic chk_irq(input string req, input logic exp);
      chk(req, {31'd0, irq_pull_low}, {31'd0, exp});
      chk("R9", {31'd0, irq_n}, {31'd0, ~exp});
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Write presented at a negedge, taken on the following posedge
   task automatic wr(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      tick();
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [5:0] s;
      // R8: reset with non-zero flags must not look like a change
      s       = 6'b101010;
      stat_in = s;
      repeat (3) tick();
      chk_irq("R8", 1'b0);
      chk("R8", {24'd0, rd_status}, 32'd0);
      rst_n = 1'b1;
      repeat (3) tick();
      chk_irq("R8", 1'b0);
      chk("R7", {24'd0, rd_status}, {26'd0, s});

      // Single flag toggles, both directions, then mask and re-enable
      for (int i = 0; i < 6; i++) begin
         s[i] = ~s[i]; stat_in = s; tick();
         chk_irq("R1", 1'b1);
         chk("R7", {24'd0, rd_status}, {26'd0, s});
         s[i] = ~s[i]; stat_in = s; tick();
         chk_irq("R3", 1'b1);
         tick();
         chk("R7", {24'd0, rd_status}, {26'd0, s});
         wr(8'(1 << i));
         chk_irq("R4", 1'b0);
         s[i] = ~s[i]; stat_in = s; tick();
         s[i] = ~s[i]; stat_in = s; tick();
         chk_irq("R5", 1'b0);
         wr(8'h00);
         chk_irq("R5", 1'b0);
         s[i] = ~s[i]; stat_in = s; tick();
         chk_irq("R1", 1'b1);
         wr(8'hFF);
         chk_irq("R4", 1'b0);
         wr(8'h00);
      end

      // Every non-empty multi-flag change pattern
      for (int p = 1; p < 64; p++) begin
         s = s ^ 6'(p); stat_in = s; tick();
         chk_irq("R1", 1'b1);
         wr(8'h3F);
         chk_irq("R4", 1'b0);
         wr(8'h00);
      end

      // Buffer events
      for (int j = 0; j < 2; j++) begin
         evt_in = 2'(1 << j); tick(); evt_in = '0;
         chk_irq("R2", 1'b1);
         chk("R7", {24'd0, rd_status}, {24'd0, 8'(1 << (6 + j)), 2'b00} >> 2 | {26'd0, s});
         tick();
         chk_irq("R3", 1'b1);
         chk("R7", {24'd0, rd_status[7:6]}, 32'(1 << j));
         wr(8'(1 << (6 + j)));
         chk_irq("R4", 1'b0);
         chk("R4", {24'd0, rd_status[7:6]}, 32'd0);
         wr(8'h00);
      end

      // Two pending sources: clearing one keeps the interrupt
      evt_in = 2'b01; s[0] = ~s[0]; stat_in = s; tick(); evt_in = '0;
      chk_irq("R1", 1'b1);
      wr(8'h01);
      chk_irq("R4", 1'b1);
      chk("R4", {24'd0, rd_status[7:6]}, 32'd1);
      wr(8'h40);
      chk_irq("R4", 1'b0);
      wr(8'h00);

      // Clear and event on the same edge: clear wins
      evt_in = 2'b01; wr(8'h40); evt_in = '0;
      chk_irq("R6", 1'b0);
      chk("R6", {24'd0, rd_status[7:6]}, 32'd0);
      // Re-enable and event on the same edge: old mask applies
      evt_in = 2'b01; wr(8'h00); evt_in = '0;
      chk_irq("R6", 1'b0);
      chk("R6", {24'd0, rd_status[7:6]}, 32'd0);
      evt_in = 2'b10; tick(); evt_in = '0;
      chk_irq("R6", 1'b1);
      chk("R6", {24'd0, rd_status[7:6]}, 32'd2);
      wr(8'hFF);

      // Everything masked: all events ignored
      evt_in = 2'b11; s = ~s; stat_in = s; tick(); evt_in = '0;
      tick();
      chk_irq("R5", 1'b0);
      chk("R5", {24'd0, rd_status}, {26'd0, s});
      wr(8'h00);
      chk_irq("R5", 1'b0);
      chk("R5", {24'd0, rd_status[7:6]}, 32'd0);

      // Repeated reads change nothing
      evt_in = 2'b11; tick(); evt_in = '0;
      repeat (4) tick();
      chk("R7", {24'd0, rd_status}, {24'd0, 2'b11, s});
      chk_irq("R7", 1'b1);

      // Reset in the middle of activity
      rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
      chk_irq("R8", 1'b0);
      chk("R8", {24'd0, rd_status[7:6]}, 32'd0);

      finish_run();
   end

endmodule